// File: doc/BRIEF.md
# TLB Exception Controller for a Software-Refilled MMU

This block makes the exception decisions for a processor whose address translation is handled entirely by a software-filled TLB. Each cycle it samples several inputs:

- the TLB lookup result (a miss or a write-protection fault);
- the kind of access (load, store or instruction fetch) and the faulting virtual address;
- the PC of the current instruction and a flag marking a branch delay slot;
- interrupt, system-call and exception-return requests.

It holds the architectural exception state: the exception-level flag, the exception PC, the cause word (code field and delay-slot flag) and the bad-address register. When it takes an exception or performs a return, it produces a one-cycle redirect with the new PC.

A TLB miss raised while the exception level is clear goes to a dedicated fast refill vector. A miss raised while a handler is already running is a nested miss. It goes to the shared general vector as an ordinary TLB load/store exception, and the saved PC and delay-slot flag of the outer exception are kept. The nested handler therefore returns to the instruction that first missed. Re-executing that instruction enters the refill path again, and this time the page table holds the entry. The hardware saves no register context beyond these few registers.

Top module: `tlbx_ctrl`

## Requirements
- R1: When an exception is taken while `exl_o` is 0, `exl_o` becomes 1, `epc_o` takes `pc_i`, and the delay-slot bit `cause_o[31]` becomes 0 when `in_delay_i` is 0.
- R2: When an exception is taken while `exl_o` is 0 and `in_delay_i` is 1, `cause_o[31]` becomes 1 and `epc_o` takes `pc_i - 4`.
- R3: A TLB miss taken while `exl_o` is 0 redirects to `REFILL_VEC` (default 0x8000_0000).
- R4: A TLB miss taken while `exl_o` is 1 redirects to `GEN_VEC` (default 0x8000_0180). The code `cause_o[6:2]` is 2 for a load or fetch miss and 3 for a store miss. `acc_kind_i` is encoded load=0, store=1, fetch=2.
- R5: While `exl_o` is 1, a newly taken exception leaves `epc_o` and `cause_o[31]` unchanged.
- R6: The following exceptions all redirect to `GEN_VEC` and differ only in `cause_o[6:2]`: interrupt (code 0), TLB write-protection fault (code 1) and system call (code 8).
- R7: With no exception request in the same cycle, `eret_i` redirects to the current `epc_o` and clears `exl_o`. When an exception request is present in the same cycle, the exception is taken and the return is ignored.
- R8: When several requests arrive in one cycle, the order of precedence is: fetch TLB miss, then interrupt, then load/store TLB miss or write-protection fault (a miss beats a fault), then system call.
- R9: `badva_o` takes `fault_va_i` on every taken TLB-related exception, nested ones included. It is unchanged when an interrupt or system call is taken.
- R10: After reset, `exl_o`, `epc_o`, `cause_o`, `badva_o` and `redirect_valid_o` are all 0.
- R11: `redirect_valid_o` is high for exactly the cycle after a taken exception or return, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tlb_miss_i | input | 1 | TLB lookup found no entry |
| tlb_mod_i | input | 1 | Store hit a write-protected entry |
| acc_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| fault_va_i | input | XLEN | Virtual address of the access |
| pc_i | input | XLEN | PC of the current instruction |
| in_delay_i | input | 1 | Instruction sits in a branch delay slot |
| irq_i | input | 1 | Interrupt request |
| syscall_i | input | 1 | System-call request |
| eret_i | input | 1 | Exception-return command |
| redirect_valid_o | output | 1 | Redirect pulse |
| redirect_pc_o | output | XLEN | Target PC of the redirect |
| exl_o | output | 1 | Exception-level flag |
| epc_o | output | XLEN | Saved exception PC |
| cause_o | output | 32 | Cause word: [31] delay slot, [6:2] code |
| badva_o | output | XLEN | Last faulting virtual address |

## Verification
Some properties are checked by the assertions on every cycle:

- a taken exception sets the exception level;
- a nested exception freezes the saved PC and delay-slot bit;
- a nested miss lands on the general vector;
- a return clears the level and jumps to the saved PC;
- the bad-address register does not move on non-TLB causes;
- the redirect pulse only follows a taken event.

Other behaviour can only be shown by the bench's scenarios. These include the exact cause codes, the delay-slot PC adjustment and precedence among simultaneous requests. They also include the full refill, nested miss, return and refill-again sequence, in which the outer PC must survive the nested handler.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] CODE_IRQ  = 5'd0;
  localparam logic [CODE_W-1:0] CODE_MOD  = 5'd1;
  localparam logic [CODE_W-1:0] CODE_TLBL = 5'd2;
  localparam logic [CODE_W-1:0] CODE_TLBS = 5'd3;
  localparam logic [CODE_W-1:0] CODE_SYS  = 5'd8;

  // Winning request of one cycle
  typedef struct packed {
    logic              take;   // some exception is taken
    logic              miss;   // winner is a TLB miss (refill candidate)
    logic              tlb;    // winner is TLB related (loads bad address)
    logic [CODE_W-1:0] code;
  } exc_sel_t;

endpackage

// File: rtl/tlbx_prio.sv
module tlbx_prio
  import tlbx_pkg::*;
(
  input  logic       tlb_miss,
  input  logic       tlb_mod,
  input  logic [1:0] acc_kind,
  input  logic       irq,
  input  logic       syscall,
  output exc_sel_t   sel
);

  logic fetch_miss, ls_miss, ls_mod;

  assign fetch_miss = tlb_miss && (acc_kind == ACC_FETCH);
  assign ls_miss    = tlb_miss && (acc_kind != ACC_FETCH);
  assign ls_mod     = tlb_mod && !tlb_miss;

  always_comb begin
    sel = '0;
    if (fetch_miss) begin
      sel = '{take: 1'b1, miss: 1'b1, tlb: 1'b1, code: CODE_TLBL};
    end else if (irq) begin
      sel = '{take: 1'b1, miss: 1'b0, tlb: 1'b0, code: CODE_IRQ};
    end else if (ls_miss) begin
      sel = '{take: 1'b1, miss: 1'b1, tlb: 1'b1,
              code: (acc_kind == ACC_STORE) ? CODE_TLBS : CODE_TLBL};
    end else if (ls_mod) begin
      sel = '{take: 1'b1, miss: 1'b0, tlb: 1'b1, code: CODE_MOD};
    end else if (syscall) begin
      sel = '{take: 1'b1, miss: 1'b0, tlb: 1'b0, code: CODE_SYS};
    end
  end

endmodule

// File: rtl/tlbx_state.sv
module tlbx_state
  import tlbx_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  exc_sel_t          sel,
  input  logic              eret,
  input  logic [XLEN-1:0]   pc,
  input  logic              in_delay,
  input  logic [XLEN-1:0]   fault_va,
  output logic              exl,
  output logic [XLEN-1:0]   epc,
  output logic              bd,
  output logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   badva
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      exl   <= 1'b0;
      epc   <= '0;
      bd    <= 1'b0;
      code  <= '0;
      badva <= '0;
    end else if (sel.take) begin
      if (!exl) begin
        exl <= 1'b1;
        bd  <= in_delay;
        epc <= in_delay ? (pc - STEP) : pc;
      end
      code <= sel.code;
      if (sel.tlb) badva <= fault_va;
    end else if (eret) begin
      exl <= 1'b0;
    end
  end

  AST_EXL_SET: assert property (@(posedge clk) disable iff (rst)
    sel.take |=> exl); // R1
  AST_NEST_KEEP: assert property (@(posedge clk) disable iff (rst)
    (sel.take && exl) |=> ($stable(epc) && $stable(bd))); // R5
  AST_BADVA_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(sel.take && sel.tlb) |=> $stable(badva)); // R9
  AST_ERET_CLR: assert property (@(posedge clk) disable iff (rst)
    (eret && !sel.take) |=> !exl); // R7

endmodule

// File: rtl/tlbx_redirect.sv
module tlbx_redirect
  import tlbx_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] REFILL_VEC = 32'h8000_0000,
  parameter logic [XLEN-1:0] GEN_VEC    = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst,
  input  exc_sel_t        sel,
  input  logic            eret,
  input  logic            exl,
  input  logic [XLEN-1:0] epc,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
    end else begin
      redir_valid <= sel.take || eret;
      if (sel.take) redir_pc <= (sel.miss && !exl) ? REFILL_VEC : GEN_VEC;
      else if (eret) redir_pc <= epc;
    end
  end

  AST_NESTED_GEN: assert property (@(posedge clk) disable iff (rst)
    (sel.take && sel.miss && exl) |=> (redir_valid && redir_pc == GEN_VEC)); // R4
  AST_FIRST_REFILL: assert property (@(posedge clk) disable iff (rst)
    (sel.take && sel.miss && !exl) |=> (redir_valid && redir_pc == REFILL_VEC)); // R3
  AST_ERET_PC: assert property (@(posedge clk) disable iff (rst)
    (eret && !sel.take) |=> (redir_valid && redir_pc == $past(epc))); // R7
  AST_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
    !(sel.take || eret) |=> !redir_valid); // R11

endmodule

// File: rtl/tlbx_ctrl.sv
module tlbx_ctrl
  import tlbx_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] REFILL_VEC = 32'h8000_0000,
  parameter logic [XLEN-1:0] GEN_VEC    = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tlb_miss_i,
  input  logic            tlb_mod_i,
  input  logic [1:0]      acc_kind_i,
  input  logic [XLEN-1:0] fault_va_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            in_delay_i,
  input  logic            irq_i,
  input  logic            syscall_i,
  input  logic            eret_i,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            exl_o,
  output logic [XLEN-1:0] epc_o,
  output logic [31:0]     cause_o,
  output logic [XLEN-1:0] badva_o
);

  exc_sel_t          sel;
  logic              bd;
  logic [CODE_W-1:0] code;

  tlbx_prio u_prio (
    .tlb_miss (tlb_miss_i),
    .tlb_mod  (tlb_mod_i),
    .acc_kind (acc_kind_i),
    .irq      (irq_i),
    .syscall  (syscall_i),
    .sel      (sel)
  );

  tlbx_state #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_state (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .eret     (eret_i),
    .pc       (pc_i),
    .in_delay (in_delay_i),
    .fault_va (fault_va_i),
    .exl      (exl_o),
    .epc      (epc_o),
    .bd       (bd),
    .code     (code),
    .badva    (badva_o)
  );

  tlbx_redirect #(.XLEN(XLEN), .REFILL_VEC(REFILL_VEC), .GEN_VEC(GEN_VEC)) u_redir (
    .clk         (clk),
    .rst         (rst),
    .sel         (sel),
    .eret        (eret_i),
    .exl         (exl_o),
    .epc         (epc_o),
    .redir_valid (redirect_valid_o),
    .redir_pc    (redirect_pc_o)
  );

  assign cause_o = {bd, 24'd0, code, 2'b00};

  AST_RST_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!redirect_valid_o && !exl_o && cause_o == 32'd0)); // R10

endmodule

// File: tb/tlbx_ctrl_tb.sv
`timescale 1ns/1ps
module tlbx_ctrl_tb;

  localparam logic [31:0] RV = 32'h8000_0000;
  localparam logic [31:0] GV = 32'h8000_0180;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tlb_miss = 0, tlb_mod = 0, in_delay = 0, irq = 0, sys = 0, eret = 0;
  logic [1:0] acc = 0;
  logic [31:0] va = 0, pc = 0;
  logic rv_o, exl_o;
  logic [31:0] rpc_o, epc_o, cause_o, bva_o;

  always #10 clk = ~clk;

  tlbx_ctrl u_dut (
    .clk(clk), .rst(rst), .tlb_miss_i(tlb_miss), .tlb_mod_i(tlb_mod),
    .acc_kind_i(acc), .fault_va_i(va), .pc_i(pc), .in_delay_i(in_delay),
    .irq_i(irq), .syscall_i(sys), .eret_i(eret),
    .redirect_valid_o(rv_o), .redirect_pc_o(rpc_o), .exl_o(exl_o),
    .epc_o(epc_o), .cause_o(cause_o), .badva_o(bva_o)
  );

  typedef struct {
    logic        v;
    logic [31:0] rpc;
    logic        exl;
    logic [31:0] epc;
    logic [31:0] cause;
    logic [31:0] bva;
    string       tag;
  } exp_t;

  exp_t q[$];
  int tests = 0, fails = 0;

  // bench-side architectural model
  logic m_exl = 0, m_bd = 0;
  logic [31:0] m_epc = 0, m_bva = 0, m_rpc = 0;
  logic [4:0] m_code = 0;

  task automatic step(input string tag, input logic mi, input logic mo, input logic [1:0] ak,
                      input logic [31:0] fva, input logic [31:0] p, input logic dl,
                      input logic ir, input logic sc, input logic er);
    exp_t e;
    logic take, is_miss, is_tlb;
    logic [4:0] c;
    @(negedge clk);
    tlb_miss = mi; tlb_mod = mo; acc = ak; va = fva; pc = p;
    in_delay = dl; irq = ir; sys = sc; eret = er;
    take = 1; is_miss = 0; is_tlb = 0; c = 0;
    if (mi && ak == 2)       begin is_miss = 1; is_tlb = 1; c = 2; end
    else if (ir)             begin c = 0; end
    else if (mi)             begin is_miss = 1; is_tlb = 1; c = (ak == 1) ? 5'd3 : 5'd2; end
    else if (mo)             begin is_tlb = 1; c = 1; end
    else if (sc)             begin c = 8; end
    else take = 0;
    e.v = take || er;
    if (take) begin
      m_rpc = (is_miss && !m_exl) ? RV : GV;
      if (!m_exl) begin
        m_exl = 1; m_bd = dl; m_epc = dl ? p - 32'd4 : p;
      end
      m_code = c;
      if (is_tlb) m_bva = fva;
    end else if (er) begin
      m_rpc = m_epc; m_exl = 0;
    end
    e.rpc = m_rpc; e.exl = m_exl; e.epc = m_epc;
    e.cause = {m_bd, 24'd0, m_code, 2'b00}; e.bva = m_bva; e.tag = tag;
    @(posedge clk); #1;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic bad;
      e = q.pop_front();
      tests++;
      bad = (rv_o !== e.v) || (exl_o !== e.exl) || (epc_o !== e.epc) ||
            (cause_o !== e.cause) || (bva_o !== e.bva) || (e.v && rpc_o !== e.rpc);
      if (bad) begin
        fails++;
        $display("FAIL %s: act v=%0b pc=%h exl=%0b epc=%h cause=%h bva=%h | exp v=%0b pc=%h exl=%0b epc=%h cause=%h bva=%h",
                 e.tag, rv_o, rpc_o, exl_o, epc_o, cause_o, bva_o,
                 e.v, e.rpc, e.exl, e.epc, e.cause, e.bva);
      end
    end
  end

  logic done = 0;
  initial begin
    #(20 * 5000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: act hung exp finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    step("R10 reset", 0,0,0, 0, 0, 0, 0,0,0);
    step("R3 R1 R9 refill", 1,0,0, 32'h7FFF_0010, 32'h0040_0100, 0, 0,0,0);
    step("R4 R5 R9 nested load", 1,0,0, 32'hC000_1000, 32'h8000_0004, 0, 0,0,0);
    step("R7 return", 0,0,0, 0, 32'h8000_0190, 0, 0,0,1);
    step("R3 refill again", 1,0,0, 32'h7FFF_0010, 32'h0040_0100, 0, 0,0,0);
    step("R7 return2", 0,0,0, 0, 0, 0, 0,0,1);
    step("R2 store delay slot", 1,0,1, 32'h1000_0008, 32'h0040_0204, 1, 0,0,0);
    step("R5 R6 nested syscall", 0,0,0, 0, 32'h8000_0010, 0, 0,1,0);
    step("R7 return3", 0,0,0, 0, 0, 0, 0,0,1);
    step("R6 R9 irq", 0,0,0, 32'h5555_0000, 32'h0040_0300, 0, 1,0,0);
    step("R7 return4", 0,0,0, 0, 0, 0, 0,0,1);
    step("R6 modify", 0,1,1, 32'h2000_0040, 32'h0040_0400, 0, 0,0,0);
    step("R4 nested store", 1,0,1, 32'hC000_2000, 32'h8000_0184, 0, 0,0,0);
    step("R7 return5", 0,0,0, 0, 0, 0, 0,0,1);
    step("R8 irq over ls", 1,0,1, 32'h3000_0000, 32'h0040_0500, 0, 1,1,0);
    step("R7 return6", 0,0,0, 0, 0, 0, 0,0,1);
    step("R8 fetch over irq", 1,0,2, 32'h0050_0000, 32'h0050_0000, 0, 1,0,0);
    step("R7 return7", 0,0,0, 0, 0, 0, 0,0,1);
    step("R7 R8 exc over eret", 0,0,0, 0, 32'h0040_0600, 0, 0,1,1);
    step("R8 miss over modify", 1,1,0, 32'h6000_0000, 32'h8000_0200, 0, 0,0,0);
    step("R7 return8", 0,0,0, 0, 0, 0, 0,0,1);
    step("R11 idle", 0,0,0, 0, 32'h0040_0700, 0, 0,0,0);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule